// File: doc/BRIEF.md
# Reset Source Sequencer with Status

This block gathers the internal reset requests of a small microcontroller: an illegal-instruction strobe from the processor core, a STOP-instruction strobe, an unmapped-address flag qualified by an opcode-fetch indication, and a low-voltage detect level. Any request turns on the pull-down of the active-low external reset pin and asserts the CPU reset. A reset status register records which cause fired.

Release is timed by a free-running 13-bit prescale counter. The counter advances on the falling edge of the input clock, and its value is resynchronised into the rising-edge domain. The pin pull-down lasts 4096 cycles. The CPU is then held for 64 more cycles before it is let go to fetch its reset vector. Each time the counter wraps, it also produces a one-cycle tick that clocks an external watchdog.

A STOP instruction is treated as illegal only when the STOP-enable configuration bit is clear. An unmapped address only counts when the access is an opcode fetch. A request that arrives while a sequence is running restarts the timing, and its cause is added to the status.

Top module: `rst_cause_seq`

## Requirements
- R1: After the asynchronous power-on reset (rstN low), pinPullDown and cpuReset are 0 and statusOut is 0.
- R2: An illegalOpStb pulse sampled on a rising edge sets statusOut bit 0 (illegal-instruction cause), and pinPullDown is 1 from the next cycle.
- R3: stopExecStb starts a reset with statusOut bit 0 when stopEnable is 0. It has no effect when stopEnable is 1.
- R4: unmappedAddr together with opFetch starts a reset with statusOut bit 1 (illegal-address cause). unmappedAddr without opFetch, or opFetch alone, has no effect.
- R5: lowVoltDet high starts a reset with statusOut bit 2 (low-voltage cause). While it stays high, the sequence restarts every cycle, so release timing runs from the last cycle it was high.
- R6: pinPullDown stays 1 for exactly PULL_CYC (4096) cycles after the last request.
- R7: cpuReset is 1 whenever pinPullDown is 1. It stays 1 for exactly HOLD_CYC (64) cycles after pinPullDown drops, then goes to 0.
- R8: A request arriving while no sequence is active replaces statusOut with only the cause bits of that request. Bits from earlier resets are cleared.
- R9: A request during an active sequence restarts the full 4096-cycle pull-down and ORs its cause bits into statusOut.
- R10: wdogTick is a one-cycle pulse that recurs every 2^13 = 8192 cycles. Reset sequences do not change its period.
- R11: statusOut keeps its value after release until the next request arrives while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the prescaler uses its falling edge, all other logic its rising edge |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| illegalOpStb | input | 1 | One-cycle strobe for an illegal instruction decoded by the core |
| stopExecStb | input | 1 | One-cycle strobe for an executed STOP instruction |
| stopEnable | input | 1 | Configuration bit; 1 permits STOP |
| opFetch | input | 1 | Current bus access is an opcode fetch |
| unmappedAddr | input | 1 | Current bus access targets an unmapped address |
| lowVoltDet | input | 1 | Low-voltage detect level |
| pinPullDown | output | 1 | Enable for the pull-down on the external reset pin |
| cpuReset | output | 1 | Reset to the CPU |
| statusOut | output | 3 | Cause bits: [0] illegal instruction, [1] illegal address, [2] low voltage |
| wdogTick | output | 1 | Watchdog prescale tick on counter wrap |

## Verification
On every cycle, the assertions check four things: any qualified cause is followed by an active pin pull-down; the pin pull-down never appears without the CPU reset; the status is non-zero whenever the CPU is held; an idle block with no qualified cause stays idle. They also check that the watchdog tick is a single-cycle pulse and that the pull-down ends with the CPU still held. Exact lengths need the bench's scenarios: 4096 cycles of pull-down, 64 cycles of hold, and 8192 cycles between ticks. So do the status rules: replacement when a request arrives while idle, merging and restart mid-sequence, and the release timing for a held low-voltage level.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  localparam int CAUSE_W    = 3;
  localparam int CAUSE_ILOP = 0;
  localparam int CAUSE_IADR = 1;
  localparam int CAUSE_LOWV = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PULL = 2'd1,
    SEQ_HOLD = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armStart;   // snapshot counter, restart elapsed time
    logic loadCause;  // replace status with current causes
    logic mergeCause; // OR current causes into status
  } seqCmd_t;

endpackage

// File: rtl/rst_cause_prescale.sv
module rst_cause_prescale #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [CNT_W-1:0] cntSync,
  output logic             wdogTick
);

  logic [CNT_W-1:0] cntNeg;

  // free-running prescaler on the falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) cntNeg <= '0;
    else       cntNeg <= cntNeg + 1'b1;
  end

  // bring the value into the rising-edge domain and flag the wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntSync  <= '0;
      wdogTick <= 1'b0;
    end else begin
      cntSync  <= cntNeg;
      wdogTick <= (cntNeg == '0) && (cntSync == {CNT_W{1'b1}});
    end
  end

endmodule

// File: rtl/rst_cause_dp.sv
module rst_cause_dp
  import rst_cause_pkg::*;
#(
  parameter int CNT_W    = 13,
  parameter int PULL_CYC = 4096,
  parameter int HOLD_CYC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   cntSync,
  input  seqCmd_t            cmd,
  input  logic [CAUSE_W-1:0] causeVec,
  output logic               pullDone,
  output logic               holdDone,
  output logic [CAUSE_W-1:0] statusOut
);

  localparam int TOTAL_CYC = PULL_CYC + HOLD_CYC;
  localparam logic [CNT_W-1:0] PULL_END  = CNT_W'(PULL_CYC);
  localparam logic [CNT_W-1:0] TOTAL_END = CNT_W'(TOTAL_CYC);

  logic [CNT_W-1:0]   startVal;
  logic [CNT_W-1:0]   elapsed;
  logic [CAUSE_W-1:0] statusQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             startVal <= '0;
    else if (cmd.armStart) startVal <= cntSync;
  end

  // modular distance from the snapshot
  assign elapsed  = cntSync - startVal;
  assign pullDone = (elapsed == PULL_END);
  assign holdDone = (elapsed == TOTAL_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               statusQ <= '0;
    else if (cmd.loadCause)  statusQ <= causeVec;
    else if (cmd.mergeCause) statusQ <= statusQ | causeVec;
  end

  assign statusOut = statusQ;

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               illegalOpStb,
  input  logic               stopExecStb,
  input  logic               stopEnable,
  input  logic               opFetch,
  input  logic               unmappedAddr,
  input  logic               lowVoltDet,
  input  logic               pullDone,
  input  logic               holdDone,
  output seqCmd_t            cmd,
  output logic [CAUSE_W-1:0] causeVec,
  output logic               pinPullDown,
  output logic               cpuReset
);

  seqState_t stateQ, stateD;
  logic      anyReq;

  // qualify each source
  always_comb begin
    causeVec             = '0;
    causeVec[CAUSE_ILOP] = illegalOpStb | (stopExecStb & ~stopEnable);
    causeVec[CAUSE_IADR] = unmappedAddr & opFetch;
    causeVec[CAUSE_LOWV] = lowVoltDet;
  end

  assign anyReq = |causeVec;

  always_comb begin
    stateD = stateQ;
    cmd    = '0;
    unique case (stateQ)
      SEQ_IDLE: begin
        if (anyReq) begin
          stateD        = SEQ_PULL;
          cmd.armStart  = 1'b1;
          cmd.loadCause = 1'b1;
        end
      end
      SEQ_PULL: begin
        if (anyReq) begin
          cmd.armStart   = 1'b1;
          cmd.mergeCause = 1'b1;
        end else if (pullDone) begin
          stateD = SEQ_HOLD;
        end
      end
      SEQ_HOLD: begin
        if (anyReq) begin
          stateD         = SEQ_PULL;
          cmd.armStart   = 1'b1;
          cmd.mergeCause = 1'b1;
        end else if (holdDone) begin
          stateD = SEQ_IDLE;
        end
      end
      default: stateD = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= SEQ_IDLE;
    else       stateQ <= stateD;
  end

  assign pinPullDown = (stateQ == SEQ_PULL);
  assign cpuReset    = (stateQ != SEQ_IDLE);

endmodule

// File: rtl/rst_cause_seq.sv
module rst_cause_seq
  import rst_cause_pkg::*;
#(
  parameter int CNT_W    = 13,
  parameter int PULL_CYC = 4096,
  parameter int HOLD_CYC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               illegalOpStb,
  input  logic               stopExecStb,
  input  logic               stopEnable,
  input  logic               opFetch,
  input  logic               unmappedAddr,
  input  logic               lowVoltDet,
  output logic               pinPullDown,
  output logic               cpuReset,
  output logic [CAUSE_W-1:0] statusOut,
  output logic               wdogTick
);

  logic [CNT_W-1:0]   cntSync;
  seqCmd_t            cmd;
  logic [CAUSE_W-1:0] causeVec;
  logic               pullDone;
  logic               holdDone;

  rst_cause_prescale #(.CNT_W(CNT_W)) prescale_i (
    .clk      (clk),
    .rstN     (rstN),
    .cntSync  (cntSync),
    .wdogTick (wdogTick)
  );

  rst_cause_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .illegalOpStb (illegalOpStb),
    .stopExecStb  (stopExecStb),
    .stopEnable   (stopEnable),
    .opFetch      (opFetch),
    .unmappedAddr (unmappedAddr),
    .lowVoltDet   (lowVoltDet),
    .pullDone     (pullDone),
    .holdDone     (holdDone),
    .cmd          (cmd),
    .causeVec     (causeVec),
    .pinPullDown  (pinPullDown),
    .cpuReset     (cpuReset)
  );

  rst_cause_dp #(
    .CNT_W    (CNT_W),
    .PULL_CYC (PULL_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cntSync   (cntSync),
    .cmd       (cmd),
    .causeVec  (causeVec),
    .pullDone  (pullDone),
    .holdDone  (holdDone),
    .statusOut (statusOut)
  );

endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk (
  input logic       clk,
  input logic       rstN,
  input logic       illegalOpStb,
  input logic       stopExecStb,
  input logic       stopEnable,
  input logic       opFetch,
  input logic       unmappedAddr,
  input logic       lowVoltDet,
  input logic       pinPullDown,
  input logic       cpuReset,
  input logic [2:0] statusOut,
  input logic       wdogTick
);

  logic qualReq;
  assign qualReq = illegalOpStb | (stopExecStb & ~stopEnable) |
                   (unmappedAddr & opFetch) | lowVoltDet;

  // R2
  req_starts_pull_chk: assert property (@(posedge clk) disable iff (!rstN)
    qualReq |=> pinPullDown);

  // R7
  pull_implies_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinPullDown |-> cpuReset);

  // R7
  pull_end_holds_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinPullDown) |-> cpuReset);

  // R8
  status_set_in_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReset |-> (statusOut != 3'b000));

  // R4
  idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuReset && !qualReq) |=> !cpuReset);

  // R11
  idle_status_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuReset && !qualReq) |=> $stable(statusOut));

  // R10
  tick_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdogTick |=> !wdogTick);

endmodule

bind rst_cause_seq rst_cause_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .illegalOpStb (illegalOpStb),
  .stopExecStb  (stopExecStb),
  .stopEnable   (stopEnable),
  .opFetch      (opFetch),
  .unmappedAddr (unmappedAddr),
  .lowVoltDet   (lowVoltDet),
  .pinPullDown  (pinPullDown),
  .cpuReset     (cpuReset),
  .statusOut    (statusOut),
  .wdogTick     (wdogTick)
);

// File: tb/rst_cause_seq_tb.sv
module rst_cause_seq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       illegalOpStb = 1'b0;
  logic       stopExecStb = 1'b0;
  logic       stopEnable = 1'b0;
  logic       opFetch = 1'b0;
  logic       unmappedAddr = 1'b0;
  logic       lowVoltDet = 1'b0;
  logic       pinPullDown;
  logic       cpuReset;
  logic [2:0] statusOut;
  logic       wdogTick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_cause_seq dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .illegalOpStb (illegalOpStb),
    .stopExecStb  (stopExecStb),
    .stopEnable   (stopEnable),
    .opFetch      (opFetch),
    .unmappedAddr (unmappedAddr),
    .lowVoltDet   (lowVoltDet),
    .pinPullDown  (pinPullDown),
    .cpuReset     (cpuReset),
    .statusOut    (statusOut),
    .wdogTick     (wdogTick)
  );

  // [9]stopEnable [8]illegal [7]stopExec [6]opFetch [5]unmapped [4]lowV
  // [3]expected fire [2:0]expected status
  localparam logic [9:0] VEC [8] = '{
    10'b0_0_0_1_1_0_1_010, // R4 opcode fetch from unmapped address
    10'b0_0_1_0_0_0_1_001, // R3 R8 STOP disabled, old bit cleared
    10'b0_0_0_0_1_0_0_001, // R4 R11 data access to unmapped: ignored
    10'b1_0_1_0_0_0_0_001, // R3 STOP enabled: ignored
    10'b0_0_0_0_0_1_1_100, // R5 low voltage
    10'b0_1_0_1_1_0_1_011, // R2 two causes at once
    10'b0_0_0_1_0_0_0_011, // R4 opcode fetch alone: ignored
    10'b0_0_1_0_0_1_1_101  // R3 R5 STOP disabled plus low voltage
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearIn();
    illegalOpStb = 1'b0; stopExecStb = 1'b0; stopEnable = 1'b0;
    opFetch = 1'b0; unmappedAddr = 1'b0; lowVoltDet = 1'b0;
  endtask

  // from a negedge where pin is high: count pull cycles, then hold cycles
  task automatic measure(input string tagPull, input string tagHold);
    int nPull = 0;
    int nHold = 0;
    while (pinPullDown) begin nPull++; @(negedge clk); end
    while (cpuReset)    begin nHold++; @(negedge clk); end
    check(tagPull, nPull, 4096);
    check(tagHold, nHold, 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin", pinPullDown, 0);
    check("R1 cpu", cpuReset, 0);
    check("R1 status", statusOut, 0);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      stopEnable   = VEC[i][9];
      illegalOpStb = VEC[i][8];
      stopExecStb  = VEC[i][7];
      opFetch      = VEC[i][6];
      unmappedAddr = VEC[i][5];
      lowVoltDet   = VEC[i][4];
      @(negedge clk);
      clearIn();
      check($sformatf("R2 vec%0d fire", i), pinPullDown, VEC[i][3]);
      check($sformatf("R8 vec%0d status", i), statusOut, VEC[i][2:0]);
      if (VEC[i][3]) measure("R6 pull length", "R7 hold length");
      else check($sformatf("R4 vec%0d cpu idle", i), cpuReset, 0);
      // R11 status kept after release
      check($sformatf("R11 vec%0d kept", i), statusOut, VEC[i][2:0]);
    end

    // R9 restart mid-sequence with merge
    @(negedge clk); illegalOpStb = 1'b1;
    @(negedge clk); clearIn();
    repeat (999) @(negedge clk);
    opFetch = 1'b1; unmappedAddr = 1'b1;
    @(negedge clk); clearIn();
    check("R9 merged status", statusOut, 3);
    measure("R9 restarted pull", "R9 hold after restart");

    // R5 held low-voltage level
    @(negedge clk); lowVoltDet = 1'b1;
    repeat (300) @(negedge clk);
    lowVoltDet = 1'b0;
    check("R5 status", statusOut, 4);
    measure("R5 pull from release", "R5 hold");

    // R10 watchdog tick period across a reset sequence
    begin
      int guard = 0;
      int gap = 0;
      while (!wdogTick && guard < 9000) begin guard++; @(negedge clk); end
      check("R10 tick seen", wdogTick, 1);
      @(negedge clk); gap = 1;
      repeat (100) begin @(negedge clk); gap++; end
      illegalOpStb = 1'b1;
      @(negedge clk); gap++; clearIn();
      while (!wdogTick && gap < 9000) begin @(negedge clk); gap++; end
      check("R10 tick period", gap, 8192);
      while (cpuReset) @(negedge clk);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule